// File: doc/BRIEF.md
# Sprite Attribute Page Copy Sequencer

This block generates the address stream for copying one memory page into a fixed sprite-attribute window. A CPU write of one byte to the control register picks the source page: that byte becomes the upper half of every source address. After the write the sequencer waits through a short start-up delay. It then emits one source/destination address pair on every fourth enabled cycle until 160 pairs have gone out. When the last pair is out it goes back to idle and clears the control byte.

The sequencer only produces address pairs. An external datapath does the memory read and write, and an external arbiter decides who owns the bus. The arbiter can use the busy output to lock the CPU out of the source bus. The cycle-enable input stops the sequencer while low. A new control write resets the sequence at any time.

Top module: `oam_page_dma`

## Requirements
- R1: After reset, busy_o, xfer_valid_o and ctrl_o are all low.
- R2: A write with wr_en_i high stores wr_data_i at the clock edge. busy_o is high from the next cycle, and ctrl_o returns the stored byte for as long as busy_o stays high.
- R3: After a write, the first four cycles with tick_i high produce no pair. The first pair appears on the fifth cycle with tick_i high.
- R4: Once transfers have begun, pairs appear on every fourth cycle with tick_i high. xfer_valid_o is never high in two consecutive cycles and is never high while tick_i is low.
- R5: Pair k (k counted from 0 to 159) carries src_addr_o = {page, 8'h00} + k.
- R6: Pair k carries dst_addr_o = 16'hFE00 + k, so it stays within 16'hFE00..16'hFE9F. Its low byte equals the low byte of the source address.
- R7: Exactly 160 pairs are emitted. From the cycle after pair 159, busy_o is low, ctrl_o reads zero and no further pairs appear.
- R8: A cycle with tick_i low leaves the sequencer unchanged. Sequencing picks up where it stopped when tick_i returns high.
- R9: A write while busy, whether in the start-up delay or during transfers, restarts at pair 0 with the new page after a fresh four-tick delay.
- R10: xfer_valid_o is high only while busy_o is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Cycle enable for the sequencer |
| wr_en_i | input | 1 | Control register write strobe |
| wr_data_i | input | 8 | Source page byte |
| ctrl_o | output | 8 | Control register read-back |
| busy_o | output | 1 | High during the start-up delay and during transfers |
| xfer_valid_o | output | 1 | One-cycle strobe marking a valid address pair |
| src_addr_o | output | 16 | Source address of the pair |
| dst_addr_o | output | 16 | Destination address of the pair |

## Verification
The assertions check on every cycle that:
- a strobe happens only while busy and with tick_i high, and never two cycles in a row;
- every pair lies inside the destination window, with its source page equal to the stored byte and matching low bytes;
- the stored byte follows a write;
- ctrl_o reads zero whenever the sequencer is idle.

Only the bench scenarios can show the things that depend on counting over time:
- the exact five-tick distance to the first pair;
- the four-tick stride under irregular enables;
- the total of 160 pairs;
- the restart back to pair 0 after a write during the delay or during transfers.

// File: rtl/oam_dma_pkg.sv
package oam_dma_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_XFER = 2'd2
  } dma_state_e;
endpackage

// File: rtl/oam_dma_seq.sv
module oam_dma_seq
  import oam_dma_pkg::*;
#(
  parameter int unsigned SPAN      = 160,
  parameter int unsigned START_DLY = 4,
  parameter int unsigned STRIDE    = 4,
  localparam int unsigned IDX_W    = (SPAN > 1) ? $clog2(SPAN) : 1,
  localparam int unsigned PH_W     = (STRIDE > 1) ? $clog2(STRIDE) : 1,
  localparam int unsigned DLY_W    = (START_DLY > 1) ? $clog2(START_DLY) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             restart_i,
  output logic             busy_o,
  output logic             slot_o,
  output logic             done_o,
  output logic [IDX_W-1:0] idx_o
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(SPAN - 1);
  localparam logic [PH_W-1:0]  LAST_PH  = PH_W'(STRIDE - 1);
  localparam logic [DLY_W-1:0] LAST_DLY = DLY_W'(START_DLY - 1);

  dma_state_e       state_q;
  logic [DLY_W-1:0] dly_q;
  logic [PH_W-1:0]  ph_q;
  logic [IDX_W-1:0] idx_q;

  assign busy_o = (state_q != ST_IDLE);
  assign slot_o = (state_q == ST_XFER) && tick_i && (ph_q == '0);
  assign done_o = slot_o && (idx_q == LAST_IDX);
  assign idx_o  = idx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      dly_q   <= '0;
      ph_q    <= '0;
      idx_q   <= '0;
    end else if (restart_i) begin
      state_q <= ST_WAIT;
      dly_q   <= '0;
      ph_q    <= '0;
      idx_q   <= '0;
    end else if (tick_i) begin
      unique case (state_q)
        ST_WAIT: begin
          if (dly_q == LAST_DLY) begin
            state_q <= ST_XFER;
            dly_q   <= '0;
          end else begin
            dly_q <= dly_q + 1'b1;
          end
        end
        ST_XFER: begin
          if (done_o) begin
            state_q <= ST_IDLE;
            ph_q    <= '0;
            idx_q   <= '0;
          end else begin
            ph_q <= (ph_q == LAST_PH) ? '0 : ph_q + 1'b1;
            if (slot_o) idx_q <= idx_q + 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  AST_SLOT_IDX_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    slot_o |-> idx_q <= LAST_IDX);  // R7
  AST_DONE_TO_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !restart_i) |=> !busy_o);  // R7
  AST_FROZEN_NO_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_i && !restart_i) |=> $stable(idx_q) && $stable(ph_q) && $stable(state_q));  // R8
endmodule

// File: rtl/oam_dma_addr.sv
module oam_dma_addr #(
  parameter int unsigned  IDX_W    = 8,
  parameter logic [15:0]  DST_BASE = 16'hFE00
) (
  input  logic [7:0]       page_i,
  input  logic [IDX_W-1:0] idx_i,
  output logic [15:0]      src_o,
  output logic [15:0]      dst_o
);
  assign src_o = {page_i, 8'h00} + 16'(idx_i);
  assign dst_o = DST_BASE + 16'(idx_i);
endmodule

// File: rtl/oam_page_dma.sv
module oam_page_dma #(
  parameter int unsigned SPAN      = 160,
  parameter int unsigned START_DLY = 4,
  parameter int unsigned STRIDE    = 4,
  parameter logic [15:0] DST_BASE  = 16'hFE00,
  localparam int unsigned IDX_W    = (SPAN > 1) ? $clog2(SPAN) : 1
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        tick_i,
  input  logic        wr_en_i,
  input  logic [7:0]  wr_data_i,
  output logic [7:0]  ctrl_o,
  output logic        busy_o,
  output logic        xfer_valid_o,
  output logic [15:0] src_addr_o,
  output logic [15:0] dst_addr_o
);
  logic [7:0]       ctrl_q;
  logic             slot, done;
  logic [IDX_W-1:0] idx;

  oam_dma_seq #(
    .SPAN(SPAN), .START_DLY(START_DLY), .STRIDE(STRIDE)
  ) u_seq (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick_i), .restart_i(wr_en_i),
    .busy_o(busy_o), .slot_o(slot), .done_o(done), .idx_o(idx)
  );

  oam_dma_addr #(.IDX_W(IDX_W), .DST_BASE(DST_BASE)) u_addr (
    .page_i(ctrl_q), .idx_i(idx), .src_o(src_addr_o), .dst_o(dst_addr_o)
  );

  // write wins over end-of-copy clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      ctrl_q <= '0;
    else if (wr_en_i) ctrl_q <= wr_data_i;
    else if (done)    ctrl_q <= '0;
  end

  assign ctrl_o       = ctrl_q;
  assign xfer_valid_o = slot;

  AST_WRITE_STORES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> busy_o && ctrl_o == $past(wr_data_i));  // R2
  AST_NO_BACK_TO_BACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xfer_valid_o |=> !xfer_valid_o);  // R4
  AST_VALID_NEEDS_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xfer_valid_o |-> tick_i);  // R4
  AST_SRC_PAGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xfer_valid_o |-> src_addr_o[15:8] == ctrl_o);  // R5
  AST_DST_WINDOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xfer_valid_o |-> (dst_addr_o >= DST_BASE) && (dst_addr_o <= DST_BASE + 16'(SPAN - 1))
      && (dst_addr_o[7:0] == src_addr_o[7:0]));  // R6
  AST_IDLE_CTRL_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> ctrl_o == 8'h00);  // R7
  AST_VALID_WHEN_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xfer_valid_o |-> busy_o);  // R10
endmodule

// File: tb/oam_page_dma_test.sv
module oam_page_dma_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0;
  logic        wr_en = 1'b0;
  logic [7:0]  wr_data = 8'h00;
  logic [7:0]  ctrl;
  logic        busy, vld;
  logic [15:0] src, dst;

  int n_chk = 0, n_fail = 0;
  int m_state = 0, m_wait = 0, m_tc = 0, m_page = 0;
  int pairs = 0, tick_cnt = 0, first_at = -1;
  int first_src = -1;

  always #2.5 clk = ~clk;

  oam_page_dma uut (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .wr_en_i(wr_en), .wr_data_i(wr_data),
    .ctrl_o(ctrl), .busy_o(busy), .xfer_valid_o(vld), .src_addr_o(src), .dst_addr_o(dst)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  // one cycle: drive at negedge, compare against model, advance model
  task automatic step(input bit w, input int d, input bit t);
    bit e_vld;
    @(negedge clk);
    wr_en = w; wr_data = 8'(d); tick = t;
    #1;
    e_vld = (m_state == 2) && t && (m_tc % 4 == 0);
    chk("R2 busy", int'(busy), int'(m_state != 0));
    chk("R2 ctrl", int'(ctrl), (m_state != 0) ? m_page : 0);
    chk("R4 valid", int'(vld), int'(e_vld));
    if (e_vld) begin
      chk("R5 src", int'(src), m_page * 256 + m_tc / 4);
      chk("R6 dst", int'(dst), 16'hFE00 + m_tc / 4);
      pairs++;
      if (first_at < 0) begin first_at = tick_cnt + 1; first_src = int'(src); end
    end
    if (t) tick_cnt++;
    if (w) begin
      m_state = 1; m_wait = 0; m_tc = 0; m_page = d;
      pairs = 0; tick_cnt = 0; first_at = -1; first_src = -1;
    end else if (t) begin
      if (m_state == 1) begin
        m_wait++;
        if (m_wait == 4) begin m_state = 2; m_tc = 0; end
      end else if (m_state == 2) begin
        if (m_tc % 4 == 0 && m_tc / 4 == 159) begin m_state = 0; m_page = 0; end
        else m_tc++;
      end
    end
  endtask

  task automatic finish_run;
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #2_000_000;
    n_chk++; n_fail++;
    $display("FAIL watchdog act=hung exp=done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    chk("R1 busy", int'(busy), 0);
    chk("R1 valid", int'(vld), 0);
    chk("R1 ctrl", int'(ctrl), 0);
    rst_n = 1'b1;

    // full copy, tick always high
    step(1, 8'hAB, 1);
    for (int i = 0; i < 700; i++) step(0, 0, 1);
    chk("R3 first pair tick", first_at, 5);
    chk("R7 pair count", pairs, 160);
    chk("R7 idle busy", int'(busy), 0);
    chk("R7 idle ctrl", int'(ctrl), 0);

    // irregular enable
    step(1, 8'h12, 0);
    for (int i = 0; i < 1200; i++) step(0, 0, (i % 3) != 1);
    chk("R8 pair count gated", pairs, 160);
    chk("R8 first pair tick", first_at, 5);
    chk("R10 idle after gated", int'(busy), 0);

    // restart during transfers
    step(1, 8'h40, 1);
    for (int i = 0; i < 60; i++) step(0, 0, 1);
    chk("R9 pre-restart pairs", pairs, 14);
    step(1, 8'h7C, 1);
    for (int i = 0; i < 700; i++) step(0, 0, 1);
    chk("R9 restart first src", first_src, 16'h7C00);
    chk("R9 restart count", pairs, 160);

    // restart during start-up delay
    step(1, 8'h05, 1);
    step(0, 0, 1);
    step(0, 0, 1);
    step(1, 8'hE0, 1);
    for (int i = 0; i < 700; i++) step(0, 0, 1);
    chk("R9 delay restart first tick", first_at, 5);
    chk("R9 delay restart src", first_src, 16'hE000);
    chk("R7 final ctrl", int'(ctrl), 0);
    finish_run();
  end
endmodule